// File: doc/BRIEF.md
# Limit-and-Count Interval Timer Bank

This block holds a set of up-counters that share one prescaled tick. One system counter drives interrupt level 10. One counter per processor drives that processor's level 14 line. In interval mode each counter advances on every tick towards a programmable limit. When the count reaches the limit, the counter returns to 1, latches its interrupt and keeps counting. The latch stays set until software reads the limit word. A second word returns the same limit without touching the latch.

A configuration word holds one bit per processor. That bit moves the processor's counter into a free-running user-timer mode, with no limit compare and no interrupt. A per-processor run word then gates the counting. Software reaches every word over a simple strobe-based register bus. Read data is registered and appears on the cycle after the read strobe.

Top module: `interval_timer_bank`

## Requirements
- R1: After synchronous reset every limit, count, interrupt latch, run bit and the configuration word read as 0, and both interrupt outputs are low.
- R2: The tick fires once every PRESCALE clocks. A write to a limit word stores the value and sets that counter's count to 1, and each later tick adds 1.
- R3: In interval mode with a nonzero limit, a tick that finds the count at or above the limit sets the count to 1 and sets the interrupt latch. The latch therefore rises once every limit*PRESCALE clocks.
- R4: A read of word 0 of a timer's block returns the limit and clears that timer's latch. A latch set on the same edge wins over the clear.
- R5: A read of word 2 of a timer's block returns the limit and leaves the latch unchanged.
- R6: A read of word 1 of a timer's block returns the count as it stood before that read's clock edge.
- R7: With a limit of 0 in interval mode, the count holds its value and the latch never rises.
- R8: The configuration word sits at byte address 16*(N_CPU+1). Bit i = 1 puts processor counter i in user-timer mode and bit i = 0 selects interval mode. The word reads back as written.
- R9: In user-timer mode the count adds 1 per tick only while bit 0 of word 3 of that processor's block (the run word) is 1. It ignores the limit and never sets the latch. The run word reads back in bit 0.
- R10: Processor counter i lives at byte address 16*i and drives irq_l14[i]. The system counter lives at byte address 16*N_CPU, is always in interval mode and drives irq_l10. Its word 3 reads as 0.
- R11: bus_rdata is 0 on every cycle that does not follow a read strobe. Addresses with nonzero low two bits select nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | clog2(16*(N_CPU+2)) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_l10 | output | 1 | System counter interrupt latch |
| irq_l14 | output | N_CPU | Per-processor interrupt latches |

## Verification
The bench builds the block with two processor counters, a 16-bit count and a prescale of 2. This keeps the interrupt periods down to a handful of clocks, so two full periods fit between register accesses. With a prescale of 2, a 10-clock run window produces exactly 5 counts whatever the tick phase. The spacing between two rises of a latch is measured in clocks and compared with limit*PRESCALE. Reads issued on the cycle right after a latch rises give counts known to the exact value.

// File: rtl/interval_timer_pkg.sv
package interval_timer_pkg;

    localparam int BUS_W = 32;

    // word slot inside a 16-byte timer block
    typedef enum logic [1:0] {
        SLOT_LIMIT    = 2'd0,
        SLOT_COUNT    = 2'd1,
        SLOT_LIMIT_NC = 2'd2,
        SLOT_AUX      = 2'd3
    } slot_e;

    typedef struct packed {
        logic  wr;
        logic  rd;
        slot_e slot;
    } access_t;

    function automatic slot_e word_slot(input logic [1:0] w);
        return slot_e'(w);
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PRESCALE = 4,
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic [PW-1:0] div_q;

    generate
        if (PRESCALE > 1) begin : g_div
            always_ff @(posedge clk) begin
                if (rst || tick) div_q <= '0;
                else             div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == PW'(PRESCALE - 1));

            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end else begin : g_every
            always_ff @(posedge clk) div_q <= '0;
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/limit_counter.sv
module limit_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             user_mode,
    input  logic             run,
    input  logic             lim_wr,
    input  logic [CNT_W-1:0] lim_wdata,
    input  logic             lim_clr,
    output logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    logic armed;
    logic hit;

    assign armed = !user_mode && (limit != '0);
    assign hit   = tick && armed && !lim_wr && (count >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            limit <= '0;
            count <= '0;
        end else if (lim_wr) begin
            limit <= lim_wdata;
            count <= CNT_W'(1);
        end else if (tick) begin
            if (user_mode) begin
                if (run) count <= count + 1'b1;
            end else if (armed) begin
                count <= hit ? CNT_W'(1) : count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          irq <= 1'b0;
        else if (hit)     irq <= 1'b1;
        else if (lim_clr) irq <= 1'b0;
    end

    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !user_mode && !lim_wr && limit != '0 && count >= limit)
        |=> (irq && count == CNT_W'(1)));
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        lim_wr |=> (count == CNT_W'(1) && limit == $past(lim_wdata)));
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        (lim_clr && !(tick && !user_mode && !lim_wr && limit != '0 && count >= limit))
        |=> !irq);
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (irq && !lim_clr) |=> irq);
    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        (!user_mode && limit == '0 && !lim_wr) |=> ($stable(count) && !$rose(irq)));
    a_r9_stop: assert property (@(posedge clk) disable iff (rst)
        (user_mode && !run && !lim_wr) |=> $stable(count));
    a_r9_no_irq: assert property (@(posedge clk) disable iff (rst)
        (user_mode && !irq) |=> !irq);
endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank
    import interval_timer_pkg::*;
#(
    parameter int N_CPU    = 2,
    parameter int CNT_W    = 32,
    parameter int PRESCALE = 4,
    localparam int ADDR_W  = $clog2(16 * (N_CPU + 2))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_l10,
    output logic [N_CPU-1:0]  irq_l14
);
    localparam int N_TMR = N_CPU + 1;   // index N_CPU is the system counter
    localparam int BLK_W = ADDR_W - 4;

    logic             tick;
    logic [BLK_W-1:0] blk;
    logic             aligned;
    access_t          acc;
    logic             cfg_hit;
    logic [N_CPU-1:0] cfg_q;
    logic [N_CPU-1:0] run_q;
    logic [N_TMR-1:0] cfg_ext;
    logic [N_TMR-1:0] run_ext;
    logic [N_TMR-1:0] irq_v;
    logic [CNT_W-1:0] lim_a [N_TMR];
    logic [CNT_W-1:0] cnt_a [N_TMR];
    logic [BUS_W-1:0] rd_mux;

    assign blk      = bus_addr[ADDR_W-1:4];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign acc.wr   = bus_wr && aligned;
    assign acc.rd   = bus_rd && aligned;
    assign acc.slot = word_slot(bus_addr[3:2]);
    assign cfg_hit  = (blk == BLK_W'(N_CPU + 1)) && (acc.slot == SLOT_LIMIT);
    assign cfg_ext  = {1'b0, cfg_q};
    assign run_ext  = {1'b0, run_q};

    tick_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    generate
        for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
            logic sel;
            assign sel = (blk == BLK_W'(t)) && (acc.slot == SLOT_LIMIT);
            limit_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk      (clk),
                .rst      (rst),
                .tick     (tick),
                .user_mode(cfg_ext[t]),
                .run      (run_ext[t]),
                .lim_wr   (acc.wr && sel),
                .lim_wdata(bus_wdata[CNT_W-1:0]),
                .lim_clr  (acc.rd && sel),
                .limit    (lim_a[t]),
                .count    (cnt_a[t]),
                .irq      (irq_v[t])
            );
        end

        for (genvar c = 0; c < N_CPU; c++) begin : g_run
            always_ff @(posedge clk) begin
                if (rst)
                    run_q[c] <= 1'b0;
                else if (acc.wr && blk == BLK_W'(c) && acc.slot == SLOT_AUX)
                    run_q[c] <= bus_wdata[0];
            end
        end
    endgenerate

    assign irq_l14 = irq_v[N_CPU-1:0];
    assign irq_l10 = irq_v[N_CPU];

    always_ff @(posedge clk) begin
        if (rst)                    cfg_q <= '0;
        else if (acc.wr && cfg_hit) cfg_q <= bus_wdata[N_CPU-1:0];
    end

    always_comb begin
        rd_mux = '0;
        for (int t = 0; t < N_TMR; t++) begin
            if (blk == BLK_W'(t)) begin
                case (acc.slot)
                    SLOT_LIMIT, SLOT_LIMIT_NC: rd_mux = BUS_W'(lim_a[t]);
                    SLOT_COUNT:                rd_mux = BUS_W'(cnt_a[t]);
                    default:                   rd_mux = BUS_W'(run_ext[t]);
                endcase
            end
        end
        if (cfg_hit) rd_mux = BUS_W'(cfg_q);
        if (!aligned) rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !bus_rd) bus_rdata <= '0;
        else                bus_rdata <= rd_mux;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_l10 && irq_l14 == '0 && bus_rdata == '0));
    a_r11_rdata_idle: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_interval_timer_bank.sv
`timescale 1ns/1ps
module sim_interval_timer_bank;
    localparam int N  = 2;
    localparam int W  = 16;
    localparam int P  = 2;
    localparam int AW = $clog2(16 * (N + 2));
    localparam logic [AW-1:0] SYS = AW'(16 * N);
    localparam logic [AW-1:0] CFG = AW'(16 * (N + 1));

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_l10;
    logic [N-1:0]  irq_l14;

    int      checks = 0;
    int      errors = 0;
    longint  cyc = 0;
    logic    rd_seen = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    interval_timer_bank #(.N_CPU(N), .CNT_W(W), .PRESCALE(P)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_l10(irq_l10), .irq_l14(irq_l14)
    );

    always @(posedge clk) begin
        rd_seen <= bus_rd;
        cyc     <= cyc + 1;
    end

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        logic [31:0] e;
        string       t;
        if (rd_seen && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata got %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_l10(output longint c);
        while (!irq_l10) @(negedge clk);
        c = cyc;
    endtask

    task automatic wait_l14(input int i, output longint c);
        while (!irq_l14[i]) @(negedge clk);
        c = cyc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint c1, c2;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq_l10", 32'(irq_l10), 0);
        chk("R1 irq_l14", 32'(irq_l14), 0);
        rd(CFG, 0, "R1 config");
        rd(0, 0, "R1 cpu0 limit");
        rd(SYS + 4, 0, "R1 sys count");
        rd(SYS + 12, 0, "R10 sys word3");
        rd(AW'(1), 0, "R11 unaligned");

        // R3/R4/R5/R6/R2 on the system counter, limit 4
        wr(SYS, 4);
        wait_l10(c1);
        rd(SYS + 8, 4, "R5 no-clear read");
        chk("R5 latch kept", 32'(irq_l10), 1);
        rd(SYS, 4, "R4 limit read");
        chk("R4 latch cleared", 32'(irq_l10), 0);
        wait_l10(c2);
        chk("R3 sys period", 32'(c2 - c1), 32'(4 * P));
        rd(SYS + 4, 1, "R6 count after wrap");
        rd(SYS + 4, 1, "R2 count before tick");
        rd(SYS + 4, 2, "R2 count after tick");
        rd(SYS, 4, "R4 clear");

        // R10/R3 on processor counter 1, limit 3
        wr(16, 3);
        wait_l14(1, c1);
        rd(16, 3, "R4 cpu1 limit read");
        chk("R10 cpu0 line idle", 32'(irq_l14[0]), 0);
        wait_l14(1, c2);
        chk("R3 cpu1 period", 32'(c2 - c1), 32'(3 * P));
        rd(16, 3, "R4 cpu1 clear");

        // R7 limit zero
        wr(16, 0);
        rd(20, 1, "R7 count after zero limit");
        repeat (20) @(negedge clk);
        rd(20, 1, "R7 count held");
        chk("R7 no latch", 32'(irq_l14[1]), 0);

        // R8/R9 user mode on processor 0
        wr(CFG, 1);
        rd(CFG, 1, "R8 config readback");
        wr(0, 3);
        rd(4, 1, "R9 stopped count");
        wr(12, 1);
        repeat (9) @(negedge clk);
        wr(12, 0);
        rd(4, 6, "R9 five ticks while running");
        rd(12, 0, "R9 run readback");
        repeat (10) @(negedge clk);
        rd(4, 6, "R9 count held when stopped");
        chk("R9 no latch past limit", 32'(irq_l14[0]), 0);

        // R8 back to interval mode: count above limit wraps on next tick
        wr(CFG, 0);
        repeat (3) @(negedge clk);
        chk("R8 interval mode latch", 32'(irq_l14[0]), 1);

        repeat (3) @(negedge clk);
        chk("scoreboard drained", 32'(exp_q.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule